// File: doc/BRIEF.md
# Dual-Chamber Pacing Controller

This block decides when to fire pacing pulses into the upper and lower chambers of a heart. It works through one atrial phase and then one ventricular phase, and repeats. At the start of each phase it restarts that chamber's interval timer. It then waits for a natural beat to be sensed on that chamber. If a beat is sensed first, the block moves straight on to the other chamber and fires no pulse. If the timer runs out first, the block fires a one-cycle pace pulse into that chamber and then moves on.

Each interval timer is a down-counter that restarts on a one-cycle command. Its expiry flag is a level that stays high from the moment the count reaches zero until the next restart. The interval is a parameter counted in clock cycles. The default is 0.8 s at 200 MHz, and a simulation can use a much shorter value.

Top module: `pm_dual_pacer`

## Requirements
- R1: An active-low asynchronous reset forces both pace outputs low at once, without waiting for a clock edge. It also reloads both timers and puts the controller in the atrial timer-restart state. After reset is released with no sensing, the first atrial pace is high in the cycle INTERVAL+2 clock edges after release.
- R2: Each pace output is high for exactly one cycle at a time. The atrial and ventricular pace outputs are never high together.
- R3: With no sensing, an atrial pace is followed by a ventricular pace INTERVAL+3 cycles later. The full atrial-plus-ventricular round takes 2*INTERVAL+6 cycles.
- R4: An atrial sense seen at a clock edge while waiting on the atrium cancels the atrial pace. The ventricular restart follows in the next cycle, and the ventricular pace comes INTERVAL+2 cycles after that restart cycle.
- R5: A ventricular sense seen while waiting on the ventricle cancels the ventricular pace and starts a new atrial phase in the next cycle. The atrial pace then comes INTERVAL+2 cycles after that restart cycle.
- R6: If a sense and its chamber's timer expiry arrive in the same cycle of the waiting state, the sense wins and no pace pulse is produced.
- R7: A sense that arrives while the controller is in a restart or pace state has no effect on the sequence. This includes a sense held high without a break.
- R8: The phases strictly alternate: every pace state is followed by the other chamber's restart state.
- R9: A timer's expiry level, once high, stays high until its restart command. A restart always clears it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sense_atr | input | 1 | Natural atrial beat detected (synchronous level) |
| sense_vent | input | 1 | Natural ventricular beat detected (synchronous level) |
| pace_atr | output | 1 | One-cycle atrial pacing pulse |
| pace_vent | output | 1 | One-cycle ventricular pacing pulse |

## Verification
The hardest case to reach from the ports is a sense arriving in the very cycle its timer expires, for both chambers. The timers are internal, so the bench counts edges from reset release and places a one-cycle sense exactly INTERVAL+1 edges after each restart. Neighbouring cases are placed the same way: a sense one cycle too late, which lands in the pace state, and a sense that lands in a restart state. These cases separate "sense wins" from "sense ignored". An asynchronous reset applied in the middle of a pace pulse shows that the output drops before the next edge.

// File: rtl/pm_pkg.sv
package pm_pkg;
   localparam int NUM_CH = 2;
   localparam int CH_ATR = 0;
   localparam int CH_VEN = 1;

   typedef enum logic [2:0] {
      S_RST_A  = 3'd0,
      S_WAIT_A = 3'd1,
      S_PACE_A = 3'd2,
      S_RST_V  = 3'd3,
      S_WAIT_V = 3'd4,
      S_PACE_V = 3'd5
   } pm_state_e;
endpackage

// File: rtl/pm_interval_timer.sv
module pm_interval_timer #(
   parameter int unsigned INTERVAL = 160_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CNT_W = $clog2(INTERVAL + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL);

   if (INTERVAL < 1) begin : g_bad_interval
      $error("pm_interval_timer: INTERVAL must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= RELOAD;
      else if (load)       cnt <= RELOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R9
   expiry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);
   // R9
   reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !expired);
endmodule

// File: rtl/pm_chamber_fsm.sv
module pm_chamber_fsm
   import pm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] sense,
   input  logic [NUM_CH-1:0] expired,
   output logic [NUM_CH-1:0] reload,
   output logic [NUM_CH-1:0] pace
);
   pm_state_e st, st_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= S_RST_A;
      else        st <= st_nxt;
   end

   always_comb begin
      st_nxt = st;
      case (st)
         S_RST_A:  st_nxt = S_WAIT_A;
         S_WAIT_A: begin
            if (sense[CH_ATR])        st_nxt = S_RST_V;
            else if (expired[CH_ATR]) st_nxt = S_PACE_A;
         end
         S_PACE_A: st_nxt = S_RST_V;
         S_RST_V:  st_nxt = S_WAIT_V;
         S_WAIT_V: begin
            if (sense[CH_VEN])        st_nxt = S_RST_A;
            else if (expired[CH_VEN]) st_nxt = S_PACE_V;
         end
         S_PACE_V: st_nxt = S_RST_A;
         default:  st_nxt = S_RST_A;
      endcase
   end

   always_comb begin
      reload         = '0;
      pace           = '0;
      reload[CH_ATR] = (st == S_RST_A);
      reload[CH_VEN] = (st == S_RST_V);
      pace[CH_ATR]   = (st == S_PACE_A);
      pace[CH_VEN]   = (st == S_PACE_V);
   end

   // R4
   atr_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT_A && sense[CH_ATR]) |=> (st == S_RST_V));
   // R5
   ven_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT_V && sense[CH_VEN]) |=> (st == S_RST_A));
   // R6
   sense_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT_A && sense[CH_ATR] && expired[CH_ATR]) |=> !pace[CH_ATR]);
   // R2
   pace_atr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pace[CH_ATR] |=> !pace[CH_ATR]);
   // R2
   pace_ven_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pace[CH_VEN] |=> !pace[CH_VEN]);
   // R8
   alternate_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pace[CH_ATR] |=> reload[CH_VEN]);
   // R8
   alternate_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pace[CH_VEN] |=> reload[CH_ATR]);
endmodule

// File: rtl/pm_dual_pacer.sv
module pm_dual_pacer
   import pm_pkg::*;
#(
   parameter int unsigned INTERVAL = 160_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sense_atr,
   input  logic sense_vent,
   output logic pace_atr,
   output logic pace_vent
);
   if (INTERVAL < 1) begin : g_bad_interval
      $error("pm_dual_pacer: INTERVAL must be at least 1");
   end

   logic [NUM_CH-1:0] sense_v, expired_v, reload_v, pace_v;

   assign sense_v[CH_ATR] = sense_atr;
   assign sense_v[CH_VEN] = sense_vent;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_tmr
      pm_interval_timer #(.INTERVAL(INTERVAL)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (reload_v[c]),
         .expired (expired_v[c])
      );
   end

   pm_chamber_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .sense   (sense_v),
      .expired (expired_v),
      .reload  (reload_v),
      .pace    (pace_v)
   );

   assign pace_atr  = pace_v[CH_ATR];
   assign pace_vent = pace_v[CH_VEN];

   // R2
   no_dual_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pace_atr && pace_vent));
endmodule

// File: tb/sim_pm_dual_pacer.sv
`timescale 1ns/100ps
module sim_pm_dual_pacer;
   localparam int unsigned N = 5;

   typedef struct {
      bit    ven;
      int    idx;
      string req;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0, sa = 1'b0, sv = 1'b0;
   logic pa, pv;
   int   checks = 0, fails = 0, idx = 0;
   bit   armed = 1'b0, done = 1'b0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   pm_dual_pacer #(.INTERVAL(N)) u0 (
      .clk(clk), .rst_n(rst_n), .sense_atr(sa), .sense_vent(sv),
      .pace_atr(pa), .pace_vent(pv));

   task automatic expect_pace(bit ven, int at, string req);
      exp_t e;
      e.ven = ven; e.idx = at; e.req = req;
      sb.push_back(e);
   endtask

   task automatic pop_cmp(bit ven);
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
         fails++;
         $display("FAIL unexpected pulse: ven=%0d at cycle %0d, expected none", ven, idx);
      end else begin
         e = sb.pop_front();
         if (e.ven != ven || e.idx != idx) begin
            fails++;
            $display("FAIL %s: pulse ven=%0d at cycle %0d, expected ven=%0d at cycle %0d",
                     e.req, ven, idx, e.ven, e.idx);
         end
      end
   endtask

   // monitor: samples away from the active edge
   always @(negedge clk) begin
      if (armed) begin
         if (pa) pop_cmp(1'b0);
         if (pv) pop_cmp(1'b1);
         idx++;
      end else begin
         idx = 0;
      end
   end

   task automatic run_case(string tag, int len, int sa_at, int sv_at,
                           bit sa_hold, bit abort_rst);
      rst_n = 1'b0; sa = 1'b0; sv = 1'b0;
      repeat (2) @(posedge clk);
      #0.5;
      checks++;
      if (pa !== 1'b0 || pv !== 1'b0) begin
         fails++;
         $display("FAIL R1 in reset (%s): pa=%b pv=%b, expected 0 0", tag, pa, pv);
      end
      @(posedge clk); #0.5;
      rst_n = 1'b1; armed = 1'b1;
      for (int j = 0; j < len; j++) begin
         @(negedge clk); #0.5;
         sa = sa_hold || (j == sa_at);
         sv = (j == sv_at);
      end
      sa = 1'b0; sv = 1'b0; armed = 1'b0;
      if (abort_rst) begin
         rst_n = 1'b0;
         #0.5;
         checks++;
         if (pa !== 1'b0 || pv !== 1'b0) begin
            fails++;
            $display("FAIL R1 async reset mid-pulse: pa=%b pv=%b, expected 0 0", pa, pv);
         end
      end
      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL %s: %0d expected pulses missing, expected 0", tag, sb.size());
         sb.delete();
      end
   endtask

   initial begin
      // R1: reset start and asynchronous reset during atrial pace (cycle N+2)
      expect_pace(1'b0, N+2, "R1");
      run_case("R1", N+3, -1, -1, 1'b0, 1'b1);
      // R3: free-running, no sensing
      expect_pace(1'b0, N+2,    "R3");
      expect_pace(1'b1, 2*N+5,  "R3");
      expect_pace(1'b0, 3*N+8,  "R3");
      expect_pace(1'b1, 4*N+11, "R3");
      run_case("R3", 4*N+13, -1, -1, 1'b0, 1'b0);
      // R4: atrial sense at edge 3->4 while waiting
      expect_pace(1'b1, N+6,   "R4");
      expect_pace(1'b0, 3*N+4, "R4");
      run_case("R4", 3*N+7, 3, -1, 1'b0, 1'b0);
      // R5: atrial sense then ventricular sense
      expect_pace(1'b0, N+10,   "R5");
      expect_pace(1'b1, 3*N+8,  "R5");
      run_case("R5", 3*N+10, 3, 7, 1'b0, 1'b0);
      // R6: senses in the exact expiry cycles (N+1 and 2N+3)
      expect_pace(1'b0, 3*N+6, "R6");
      expect_pace(1'b1, 5*N+4, "R6");
      run_case("R6", 5*N+6, N+1, 2*N+3, 1'b0, 1'b0);
      // R7: sense during pace state and during restart state ignored
      expect_pace(1'b0, N+2,   "R7");
      expect_pace(1'b1, 2*N+5, "R7");
      expect_pace(1'b0, 3*N+8, "R7");
      run_case("R7", 3*N+10, N+2, 2*N+6, 1'b0, 1'b0);
      // R7/R8: atrial sense held high, only ventricular paces
      expect_pace(1'b1, N+4,   "R8");
      expect_pace(1'b1, 2*N+9, "R8");
      run_case("R8", 2*N+12, -1, -1, 1'b1, 1'b0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule